// File: doc/BRIEF.md
# Speed-Aware Bulk Loopback Buffer

This block returns bulk data from a device's receive endpoint to its paired transmit endpoint. Bytes arriving on the OUT stream are written into a ring of packet slots. Each slot that is complete is replayed unchanged on the IN stream, with its own end-of-packet marker. The slot limit is the maximum packet size that belongs to the negotiated bus speed.

Link-level events control the loop. A configuration event starts it. A configuration event that arrives while the loop is already running flushes the loop and starts it again, and it takes the speed code again at that point. A bus reset or a disconnect halts the loop and discards every byte it holds. Both streams use a valid/ready handshake, with a last flag on the final byte of a packet.

Top module: `bulk_loop_buffer`

## Requirements
- R1: After reset, `out_ready`, `in_valid` and `active` are low, and they stay low until a configuration event.
- R2: A configuration event alone (no reset or disconnect event in the same cycle) sets `active`. From the next cycle `out_ready` is high, because the ring is empty.
- R3: The slot limit is taken from `speed`: code 0 gives 64 bytes, code 1 gives 512, code 2 gives 1024, and code 3 is treated as 64. When a slot reaches the limit it closes even if `out_last` is not set. On the IN side, `in_last` is high on the final byte of each slot.
- R4: Bytes leave on the IN stream in exactly the order they were accepted on the OUT stream, and with the same values. While `in_valid` is high and `in_ready` is low, `in_data` and `in_last` hold steady.
- R5: An OUT byte accepted with `out_last` high closes its slot. The slot is replayed as a packet of the same, shorter length.
- R6: A configuration event while `active` is high discards every held byte, so `in_valid` is low on the next cycle. The loop stays active and takes the speed code again.
- R7: A bus reset or disconnect event clears `active` and discards all held bytes, so `in_valid` and `out_ready` are low on the next cycle. If one of these events arrives in the same cycle as a configuration event, the stop wins.
- R8: With NBUF slots closed and waiting, `out_ready` is low. It returns one cycle after the IN side takes the last byte of a slot. A slot may close in the same cycle as another slot drains.
- R9: A change of `speed` while the loop is active has no effect on the slot limit until the next configuration event.
- R10: A byte handshaken on either stream in the same cycle as any event is discarded. It is neither stored nor counted as consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| speed | input | 2 | Bus speed code (0 full, 1 high, 2 super, 3 treated as full) |
| ev_config | input | 1 | One-cycle strobe for a set-configuration event |
| ev_reset | input | 1 | One-cycle strobe for a bus reset event |
| ev_disconnect | input | 1 | One-cycle strobe for a disconnect event |
| out_valid | input | 1 | OUT stream byte valid |
| out_data | input | 8 | OUT stream byte |
| out_last | input | 1 | OUT stream end-of-packet flag |
| out_ready | output | 1 | Block can accept an OUT byte |
| in_valid | output | 1 | IN stream byte valid |
| in_data | output | 8 | IN stream byte |
| in_last | output | 1 | Final byte of the current slot |
| in_ready | input | 1 | Consumer accepts the IN byte |
| active | output | 1 | Loop running |

## Verification
The critical coincidence is an event strobe in the same cycle as a byte handshake. The bench provokes it in two ways. In the first, it holds a single last-flagged OUT byte and a configuration pulse in one cycle. In the second, it fires a configuration pulse in the middle of a running packet while the consumer accepts randomly. The discarded byte must not reappear: `in_valid` must be low afterwards, and the behavioural queue model, which drops that cycle's transfers, must agree with every later output. A second coincidence, a slot closing while another slot drains on a full ring, is reached by the randomized traffic and judged by the same per-cycle comparison of `out_ready`.

// File: rtl/bulk_loop_buffer.sv
module bulk_loop_buffer #(
  parameter int NBUF   = 4,
  parameter int MAXPKT = 1024,
  parameter int FS_MPS = 64,
  parameter int HS_MPS = 512,
  parameter int SS_MPS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed,
  input  logic       ev_config,
  input  logic       ev_reset,
  input  logic       ev_disconnect,
  input  logic       out_valid,
  input  logic [7:0] out_data,
  input  logic       out_last,
  output logic       out_ready,
  output logic       in_valid,
  output logic [7:0] in_data,
  output logic       in_last,
  input  logic       in_ready,
  output logic       active
);
  localparam int BW = $clog2(NBUF);
  localparam int PW = $clog2(MAXPKT);
  localparam int LW = PW + 1;
  localparam int CW = $clog2(NBUF + 1);
  localparam int DEPTH = NBUF * MAXPKT;

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] len [NBUF];
  logic [LW-1:0] mps_r, mps_sel;
  logic [BW-1:0] wr_buf, rd_buf;
  logic [PW-1:0] wr_pos, rd_pos;
  logic [CW-1:0] count;

  logic stop, evt, out_fire, in_fire, wr_done, rd_done;

  assign stop     = ev_reset | ev_disconnect;
  assign evt      = stop | ev_config;
  assign mps_sel  = (speed == 2'd1) ? LW'(HS_MPS) :
                    (speed == 2'd2) ? LW'(SS_MPS) : LW'(FS_MPS);

  assign out_ready = active && (count != CW'(NBUF));
  assign in_valid  = active && (count != '0);
  assign in_data   = mem[{rd_buf, rd_pos}];
  assign in_last   = (LW'(rd_pos) + LW'(1)) == len[rd_buf];

  assign out_fire = out_valid && out_ready && !evt;
  assign in_fire  = in_valid && in_ready && !evt;
  assign wr_done  = out_fire && (out_last || ((LW'(wr_pos) + LW'(1)) == mps_r));
  assign rd_done  = in_fire && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      mps_r  <= LW'(FS_MPS);
      wr_buf <= '0;
      rd_buf <= '0;
      wr_pos <= '0;
      rd_pos <= '0;
      count  <= '0;
    end else if (evt) begin
      active <= !stop;
      if (!stop) mps_r <= mps_sel;
      wr_buf <= '0;
      rd_buf <= '0;
      wr_pos <= '0;
      rd_pos <= '0;
      count  <= '0;
    end else begin
      if (out_fire) wr_pos <= wr_done ? '0 : wr_pos + PW'(1);
      if (wr_done)  wr_buf <= wr_buf + BW'(1);
      if (in_fire)  rd_pos <= rd_done ? '0 : rd_pos + PW'(1);
      if (rd_done)  rd_buf <= rd_buf + BW'(1);
      count <= count + CW'(wr_done) - CW'(rd_done);
    end
  end

  always_ff @(posedge clk) begin
    if (out_fire) mem[{wr_buf, wr_pos}] <= out_data;
    if (wr_done)  len[wr_buf] <= LW'(wr_pos) + LW'(1);
  end
endmodule

module bulk_loop_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_config,
  input logic       ev_reset,
  input logic       ev_disconnect,
  input logic       out_ready,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_last,
  input logic       active
);
  logic quiet;
  assign quiet = !ev_config && !ev_reset && !ev_disconnect;

  a_r7_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reset || ev_disconnect) |=> (!in_valid && !out_ready && !active));

  a_r2_config_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_config && !ev_reset && !ev_disconnect) |=> (out_ready && active));

  a_r6_config_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_config |=> !in_valid);

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !(in_valid && in_ready) && quiet) |=> !out_ready);

  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && quiet) |=> (in_valid && $stable(in_data) && $stable(in_last)));

  a_r1_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && quiet) |=> (!active && !in_valid && !out_ready));
endmodule

bind bulk_loop_buffer bulk_loop_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_config(ev_config), .ev_reset(ev_reset),
  .ev_disconnect(ev_disconnect), .out_ready(out_ready), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .active(active)
);

// File: tb/bulk_loop_buffer_test.sv
module bulk_loop_buffer_test;
  localparam int NBUF = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] speed = 0;
  logic ev_config = 0, ev_reset = 0, ev_disconnect = 0;
  logic out_valid = 0, out_last = 0, in_ready = 0;
  logic [7:0] out_data = 0;
  logic out_ready, in_valid, in_last, active;
  logic [7:0] in_data;

  bulk_loop_buffer #(.NBUF(NBUF)) uut (
    .clk(clk), .rst_n(rst_n), .speed(speed), .ev_config(ev_config),
    .ev_reset(ev_reset), .ev_disconnect(ev_disconnect), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .active(active)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit rand_rdy = 0;
  logic [7:0] byte_ctr = 0;

  logic [7:0] data_q[$];
  int len_q[$];
  int got_lens[$];
  int m_mps = 64, cur_len = 0, rd_pos = 0, cur_in = 0;
  bit m_active = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic int dec_mps(logic [1:0] s);
    return (s == 2'd1) ? 512 : (s == 2'd2) ? 1024 : 64;
  endfunction

  always @(posedge clk) begin
    bit ex_rdy, ex_val, evt, stop;
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    ex_rdy = m_active && (len_q.size() < NBUF);
    ex_val = m_active && (len_q.size() > 0);
    stop = ev_reset || ev_disconnect;
    evt = stop || ev_config;
    if (!rst_n) begin
      m_active = 0; data_q.delete(); len_q.delete(); cur_len = 0; rd_pos = 0; cur_in = 0;
    end else if (evt) begin
      data_q.delete(); len_q.delete(); cur_len = 0; rd_pos = 0; cur_in = 0;
      if (stop) m_active = 0;
      else begin m_active = 1; m_mps = dec_mps(speed); end
    end else begin
      if (in_valid && in_ready) begin
        cur_in++;
        if (in_last) begin got_lens.push_back(cur_in); cur_in = 0; end
      end
      if (ex_val && in_ready) begin
        void'(data_q.pop_front());
        if (rd_pos == len_q[0] - 1) begin void'(len_q.pop_front()); rd_pos = 0; end
        else rd_pos++;
      end
      if (ex_rdy && out_valid) begin
        data_q.push_back(out_data);
        cur_len++;
        if (out_last || cur_len == m_mps) begin len_q.push_back(cur_len); cur_len = 0; end
      end
    end
    #1;
    ex_rdy = m_active && (len_q.size() < NBUF);
    ex_val = m_active && (len_q.size() > 0);
    chk(out_ready == ex_rdy, "R8 out_ready", out_ready, ex_rdy);
    chk(in_valid == ex_val, "R7 in_valid", in_valid, ex_val);
    chk(active == m_active, "R2 active", active, m_active);
    if (ex_val) begin
      chk(in_data == data_q[0], "R4 in_data", in_data, data_q[0]);
      chk(in_last == (rd_pos == len_q[0] - 1), "R3 in_last", in_last, rd_pos == len_q[0] - 1);
    end
  end

  task automatic send_byte(bit lst);
    bit ok;
    do begin
      @(negedge clk);
      out_valid = 1; out_data = byte_ctr; out_last = lst;
      if (rand_rdy) in_ready = $urandom_range(0, 1);
      ok = out_ready;
    end while (!ok);
    byte_ctr++;
  endtask

  task automatic send_pkt(int n, bit lst = 1);
    for (int i = 0; i < n; i++) send_byte(lst && (i == n - 1));
    @(negedge clk);
    out_valid = 0; out_last = 0;
  endtask

  task automatic drain();
    in_ready = 1;
    while (in_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(bit c, bit r, bit d);
    @(negedge clk);
    ev_config = c; ev_reset = r; ev_disconnect = d;
    @(negedge clk);
    ev_config = 0; ev_reset = 0; ev_disconnect = 0;
  endtask

  task automatic chk_lens(string tag, int n, int l0, int l1);
    chk(got_lens.size() == n, {tag, " packet count"}, got_lens.size(), n);
    if (n > 0 && got_lens.size() > 0) chk(got_lens[0] == l0, {tag, " length 0"}, got_lens[0], l0);
    if (n > 1 && got_lens.size() > 1) chk(got_lens[1] == l1, {tag, " length 1"}, got_lens[1], l1);
    got_lens.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(out_ready == 0, "R1 out_ready", out_ready, 0);
    chk(in_valid == 0, "R1 in_valid", in_valid, 0);

    speed = 0;
    pulse(1, 0, 0);
    chk(out_ready == 1, "R2 ready after config", out_ready, 1);

    in_ready = 1;
    send_pkt(70); drain();
    chk_lens("R3 full-speed split", 2, 64, 6);

    send_pkt(10); drain();
    chk_lens("R5 short packet", 1, 10, 0);

    speed = 2;
    send_pkt(100); drain();
    chk_lens("R9 speed ignored while active", 2, 64, 36);

    speed = 1; in_ready = 0;
    send_pkt(5); send_pkt(20, 0);
    @(negedge clk);
    chk(in_valid == 1, "R6 data held before reconfig", in_valid, 1);
    pulse(1, 0, 0);
    chk(in_valid == 0, "R6 flushed by reconfig", in_valid, 0);
    chk(active == 1, "R6 still active", active, 1);
    in_ready = 1;
    send_pkt(600); drain();
    chk_lens("R6 high-speed after restart", 2, 512, 88);

    in_ready = 0;
    for (int i = 0; i < NBUF; i++) send_pkt(3);
    @(negedge clk);
    chk(out_ready == 0, "R8 ring full", out_ready, 0);
    in_ready = 1;
    repeat (3) @(negedge clk);
    chk(out_ready == 1, "R8 ready after drain", out_ready, 1);
    drain();
    chk_lens("R8 drained count", NBUF, 3, 3);

    in_ready = 0;
    send_pkt(4); send_pkt(4);
    pulse(0, 1, 0);
    chk(in_valid == 0 && out_ready == 0, "R7 reset stops", {in_valid, out_ready}, 0);
    pulse(1, 1, 0);
    chk(active == 0, "R7 stop beats config", active, 0);
    pulse(1, 0, 0);
    send_pkt(3);
    pulse(0, 0, 1);
    chk(in_valid == 0 && active == 0, "R7 disconnect stops", {in_valid, active}, 0);
    pulse(1, 0, 0);
    in_ready = 1;
    send_pkt(7); drain();
    chk_lens("R7 nothing stale after restart", 1, 7, 0);

    in_ready = 0;
    @(negedge clk);
    out_valid = 1; out_last = 1; out_data = 8'hA5; ev_config = 1;
    @(negedge clk);
    out_valid = 0; out_last = 0; ev_config = 0;
    chk(in_valid == 0, "R10 byte in event cycle dropped", in_valid, 0);

    speed = 0;
    pulse(1, 0, 0);
    rand_rdy = 1;
    fork
      send_pkt(50);
      begin repeat (12) @(negedge clk); ev_config = 1; @(negedge clk); ev_config = 0; end
    join
    for (int p = 0; p < 30; p++) send_pkt($urandom_range(1, 150));
    rand_rdy = 0;
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule